// File: doc/BRIEF.md
# Core Idle-State Snoop Controller

This block sits beside one processor core and decides how that core idles once it halts. Software picks, through a policy input, between a shallow idle state and a deep one. In the shallow state the core stays visible to coherence traffic, and any snoop that arrives wakes it so it can answer. In the deep state the core gets out of the coherence domain. The controller first asks an external engine to write the core's first-level caches back into the shared L2. Only after that engine acknowledges does it drop the snoop-enable output, which tells the snoop filter to stop sending this core snoops.

A budget counter bounds the extra time spent entering the deep state. If the flush is not acknowledged within `FLUSH_BUDGET` cycles, the controller gives up and settles in the shallow state. The core stays snoopable in that case, so coherence stays correct. The default of 250 cycles matches one microsecond at a 250 MHz clock.

A wake that arrives while the flush is running is remembered. The flush is allowed to finish, and the core then returns to running. When the core leaves the deep state, snoop-enable is raised one cycle before the status output reports running.

Top module: `idle_snoop_ctrl`

## Requirements
- R1: After reset, `coreState` is 0 (running), `snoopEn` is 1 and `flushReq` is 0. The state encoding is 0 = running, 1 = shallow idle, 2 = flushing, 3 = deep idle.
- R2: In the running state, `idleReq` with `deepPolicy`=0 moves the core to shallow idle (state 1) on the next cycle. `snoopEn` stays 1 and `flushReq` stays 0.
- R3: In shallow idle, `snoopIn` or `wake` returns the core to running on the next cycle.
- R4: In the running state, `idleReq` with `deepPolicy`=1 moves the core to flushing (state 2) on the next cycle. `flushReq` is 1 and `snoopEn` stays 1 for as long as the flush lasts.
- R5: A `flushAck` while flushing, with no wake seen during the flush, moves the core to deep idle (state 3) on the next cycle. In that cycle `snoopEn` is 0 and `flushReq` is 0.
- R6: A `wake` during the flush, including in the cycle of the acknowledge, keeps the core flushing until the acknowledge arrives. The core then goes to running with `snoopEn`=1.
- R7: In deep idle, `snoopIn` has no effect: the state stays 3 and `snoopEn` stays 0.
- R8: A `wake` in deep idle raises `snoopEn` on the next cycle while `coreState` still reads 3. `coreState` reads 0 one cycle after that.
- R9: If no acknowledge arrives within `FLUSH_BUDGET` flushing cycles, the core leaves flushing after exactly that many cycles. It goes to shallow idle, or to running if a wake was seen. `flushReq` drops and `snoopEn` stays 1.
- R10: `idleReq` and `deepPolicy` have no effect outside the running state.
- R11: `flushAck` has no effect outside the flushing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idleReq | input | 1 | Core has halted and asks to idle |
| deepPolicy | input | 1 | Software policy: 1 selects deep idle, 0 selects shallow idle |
| snoopIn | input | 1 | A snoop is arriving for this core |
| wake | input | 1 | Break event that wakes the core |
| flushAck | input | 1 | Flush engine reports the L1 write-back is complete |
| flushReq | output | 1 | Asks the flush engine to write back the L1 caches |
| snoopEn | output | 1 | 1 while the snoop filter must send snoops to this core |
| coreState | output | 2 | Current state: 0 running, 1 shallow, 2 flushing, 3 deep |

## Verification
The bench builds the block with `FLUSH_BUDGET` set to 6 rather than 250. With that value the timeout path can be reached in a handful of cycles. The budget edge can then be hit in both directions: an acknowledge on the last allowed cycle, and the fallback to shallow idle one cycle later when no acknowledge comes. The smaller budget also lets random traffic reach the timeout often, mixed with wakes, snoops and acknowledges that land in every state.

// File: rtl/idle_snoop_pkg.sv
package idle_snoop_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SHALLOW = 3'd1,
    ST_FLUSH   = 3'd2,
    ST_DEEP    = 3'd3,
    ST_RESTORE = 3'd4
  } idleState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic cntStep;
    logic cntClear;
    logic pendSet;
    logic pendClear;
  } dpStrobe_t;

  localparam logic [1:0] CS_RUN     = 2'd0;
  localparam logic [1:0] CS_SHALLOW = 2'd1;
  localparam logic [1:0] CS_FLUSH   = 2'd2;
  localparam logic [1:0] CS_DEEP    = 2'd3;

endpackage

// File: rtl/idle_snoop_dp.sv
module idle_snoop_dp
  import idle_snoop_pkg::*;
#(
  parameter int FLUSH_BUDGET = 250
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic      budgetOut,
  output logic      wakePend
);
  localparam int CNT_W = (FLUSH_BUDGET < 2) ? 1 : $clog2(FLUSH_BUDGET + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FLUSH_BUDGET - 1);

  logic [CNT_W-1:0] flushCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 flushCnt <= '0;
    else if (strobe.cntClear)  flushCnt <= '0;
    else if (strobe.cntStep)   flushCnt <= flushCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wakePend <= 1'b0;
    else if (strobe.pendClear) wakePend <= 1'b0;
    else if (strobe.pendSet)   wakePend <= 1'b1;
  end

  assign budgetOut = (flushCnt == LAST);

endmodule

// File: rtl/idle_snoop_fsm.sv
module idle_snoop_fsm
  import idle_snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleReq,
  input  logic       deepPolicy,
  input  logic       snoopIn,
  input  logic       wake,
  input  logic       flushAck,
  input  logic       budgetOut,
  input  logic       wakePend,
  output dpStrobe_t  strobe,
  output logic       flushReq,
  output logic       snoopEn,
  output logic [1:0] coreState
);
  idleState_e state, stateNxt;
  logic inFlush, wakeSeen;

  assign inFlush  = (state == ST_FLUSH);
  assign wakeSeen = wake | wakePend;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN:
        if (idleReq) stateNxt = deepPolicy ? ST_FLUSH : ST_SHALLOW;
      ST_SHALLOW:
        if (wake || snoopIn) stateNxt = ST_RUN;
      ST_FLUSH:
        if (flushAck)       stateNxt = wakeSeen ? ST_RUN : ST_DEEP;
        else if (budgetOut) stateNxt = wakeSeen ? ST_RUN : ST_SHALLOW;
      ST_DEEP:
        if (wake) stateNxt = ST_RESTORE;
      ST_RESTORE:
        stateNxt = ST_RUN;
      default:
        stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe.cntStep   = inFlush;
    strobe.cntClear  = !inFlush;
    strobe.pendSet   = inFlush & wake;
    strobe.pendClear = !inFlush;
  end

  assign flushReq = inFlush;
  assign snoopEn  = (state != ST_DEEP);

  always_comb begin
    unique case (state)
      ST_RUN:     coreState = CS_RUN;
      ST_SHALLOW: coreState = CS_SHALLOW;
      ST_FLUSH:   coreState = CS_FLUSH;
      default:    coreState = CS_DEEP;
    endcase
  end

endmodule

// File: rtl/idle_snoop_ctrl.sv
module idle_snoop_ctrl
  import idle_snoop_pkg::*;
#(
  parameter int FLUSH_BUDGET = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleReq,
  input  logic       deepPolicy,
  input  logic       snoopIn,
  input  logic       wake,
  input  logic       flushAck,
  output logic       flushReq,
  output logic       snoopEn,
  output logic [1:0] coreState
);
  dpStrobe_t strobe;
  logic budgetOut, wakePend;

  idle_snoop_fsm u_fsm (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .deepPolicy(deepPolicy),
    .snoopIn(snoopIn), .wake(wake), .flushAck(flushAck),
    .budgetOut(budgetOut), .wakePend(wakePend), .strobe(strobe),
    .flushReq(flushReq), .snoopEn(snoopEn), .coreState(coreState)
  );

  idle_snoop_dp #(.FLUSH_BUDGET(FLUSH_BUDGET)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .budgetOut(budgetOut), .wakePend(wakePend)
  );

endmodule

// File: rtl/idle_snoop_ctrl_chk.sv
module idle_snoop_ctrl_chk #(
  parameter int FLUSH_BUDGET = 250
) (
  input logic       clk,
  input logic       rstN,
  input logic       snoopIn,
  input logic       wake,
  input logic       flushAck,
  input logic       flushReq,
  input logic       snoopEn,
  input logic [1:0] coreState
);
  localparam int CW = $clog2(FLUSH_BUDGET + 2);
  logic [CW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runLen <= '0;
    else if (flushReq) runLen <= runLen + CW'(1);
    else               runLen <= '0;
  end

  a_r1_reset_running: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (coreState == 2'd0 && snoopEn && !flushReq));

  a_r2_shallow_snoopable: assert property (@(posedge clk) disable iff (!rstN)
    (coreState == 2'd1) |-> (snoopEn && !flushReq));

  a_r4_flush_keeps_snoop: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> snoopEn);

  a_r5_snoop_off_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(snoopEn) |-> ($past(flushAck) && $past(flushReq)));

  a_r7_deep_ignores_snoop: assert property (@(posedge clk) disable iff (!rstN)
    (!snoopEn && snoopIn && !wake) |=> (!snoopEn && coreState == 2'd3));

  a_r8_snoop_before_run: assert property (@(posedge clk) disable iff (!rstN)
    ($past(coreState) == 2'd3 && coreState == 2'd0) |-> $past(snoopEn));

  a_r9_flush_budget: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (runLen < CW'(FLUSH_BUDGET)));

endmodule

bind idle_snoop_ctrl idle_snoop_ctrl_chk #(.FLUSH_BUDGET(FLUSH_BUDGET)) u_chk (
  .clk(clk), .rstN(rstN), .snoopIn(snoopIn), .wake(wake), .flushAck(flushAck),
  .flushReq(flushReq), .snoopEn(snoopEn), .coreState(coreState)
);

// File: tb/idle_snoop_ctrl_test.sv
module idle_snoop_ctrl_test;
  localparam int BUDGET = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idleReq = 0, deepPolicy = 0, snoopIn = 0, wake = 0, flushAck = 0;
  logic flushReq, snoopEn;
  logic [1:0] coreState;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model: 0 run,1 shallow,2 flush,3 deep,4 deep-restoring
  int mSt = 0, mCnt = 0;
  bit mPend = 0;

  always #2 clk = ~clk;

  idle_snoop_ctrl #(.FLUSH_BUDGET(BUDGET)) uut (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .deepPolicy(deepPolicy),
    .snoopIn(snoopIn), .wake(wake), .flushAck(flushAck),
    .flushReq(flushReq), .snoopEn(snoopEn), .coreState(coreState)
  );

  function automatic int expState(int s);
    return (s == 4) ? 3 : s;
  endfunction

  function automatic bit expSnoop(int s);
    return s != 3;
  endfunction

  task automatic modelEdge();
    int nxt = mSt;
    bit seen = wake | mPend;
    case (mSt)
      0: if (idleReq) nxt = deepPolicy ? 2 : 1;
      1: if (wake || snoopIn) nxt = 0;
      2: if (flushAck) nxt = seen ? 0 : 3;
         else if (mCnt == BUDGET - 1) nxt = seen ? 0 : 1;
      3: if (wake) nxt = 4;
      default: nxt = 0;
    endcase
    if (mSt == 2) begin
      mCnt++;
      if (wake) mPend = 1;
    end else begin
      mCnt = 0;
      mPend = 0;
    end
    mSt = nxt;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chkAll(string req);
    chk({req, " state"}, coreState, expState(mSt));
    chk({req, " snoopEn"}, snoopEn, expSnoop(mSt));
    chk({req, " flushReq"}, flushReq, mSt == 2);
  endtask

  // drive inputs, take one edge, then sample at negedge
  task automatic cyc(bit i, bit p, bit s, bit w, bit a);
    idleReq = i; deepPolicy = p; snoopIn = s; wake = w; flushAck = a;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int dummy = $urandom(32'h1d1e);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", coreState, 0); chk("R1 snoopEn", snoopEn, 1); chk("R1 flushReq", flushReq, 0);

    // R11 ack while running has no effect
    cyc(0,0,0,0,1); chkAll("R11");
    // R2 shallow entry, R10 idleReq/policy ignored in shallow, R3 snoop wakes
    cyc(1,0,0,0,0); chk("R2 state", coreState, 1); chk("R2 snoopEn", snoopEn, 1);
    cyc(1,1,0,0,1); chk("R10 shallow", coreState, 1); chk("R11 shallow", flushReq, 0);
    cyc(0,0,1,0,0); chk("R3 snoop wake", coreState, 0);
    cyc(1,0,0,0,0); cyc(0,0,0,1,0); chk("R3 wake", coreState, 0);

    // R4 deep entry; R5 ack after 3 cycles
    cyc(1,1,0,0,0); chk("R4 state", coreState, 2); chk("R4 flushReq", flushReq, 1); chk("R4 snoopEn", snoopEn, 1);
    cyc(0,0,1,0,0); cyc(1,0,0,0,0); chk("R10 flushing", coreState, 2);
    cyc(0,0,0,0,1); chk("R5 state", coreState, 3); chk("R5 snoopEn", snoopEn, 0); chk("R5 flushReq", flushReq, 0);
    // R7 snoops ignored in deep; R10 idleReq ignored in deep
    cyc(0,0,1,0,0); chk("R7 state", coreState, 3); chk("R7 snoopEn", snoopEn, 0);
    cyc(1,1,1,0,1); chk("R10 deep", coreState, 3); chk("R11 deep", snoopEn, 0);
    // R8 two-cycle exit
    cyc(0,0,0,1,0); chk("R8 snoopEn first", snoopEn, 1); chk("R8 state first", coreState, 3);
    cyc(0,0,0,0,0); chk("R8 running", coreState, 0);

    // R6 wake during flush, ack later
    cyc(1,1,0,0,0); cyc(0,0,0,1,0); chk("R6 still flushing", coreState, 2);
    cyc(0,0,0,0,1); chk("R6 state", coreState, 0); chk("R6 snoopEn", snoopEn, 1);
    // R6 wake in same cycle as ack
    cyc(1,1,0,0,0); cyc(0,0,0,1,1); chk("R6 same-cycle", coreState, 0);

    // R9 ack on last allowed cycle still reaches deep
    cyc(1,1,0,0,0);
    for (int k = 0; k < BUDGET - 1; k++) cyc(0,0,0,0,0);
    chk("R9 last cycle flushing", coreState, 2);
    cyc(0,0,0,0,1); chk("R9 ack at limit", coreState, 3);
    cyc(0,0,0,1,0); cyc(0,0,0,0,0);
    // R9 timeout -> shallow
    cyc(1,1,0,0,0);
    for (int k = 0; k < BUDGET - 1; k++) cyc(0,0,0,0,0);
    chk("R9 before timeout", coreState, 2);
    cyc(0,0,0,0,0); chk("R9 timeout state", coreState, 1);
    chk("R9 flushReq", flushReq, 0); chk("R9 snoopEn", snoopEn, 1);
    cyc(0,0,0,1,0);
    // R9 timeout with pending wake -> running
    cyc(1,1,0,0,0); cyc(0,0,0,1,0);
    for (int k = 0; k < BUDGET - 2; k++) cyc(0,0,0,0,0);
    cyc(0,0,0,0,0); chk("R9 timeout wake", coreState, 0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 10) < 3, $urandom % 2, ($urandom % 10) < 2,
          ($urandom % 10) < 1, ($urandom % 4) == 0);
      chkAll("R10 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule